// File: doc/BRIEF.md
# Branch Control Hazard Unit

This block steers instruction fetch around conditional branches in a simple in-order pipeline. The branch is resolved in decode, one stage after fetch. By then the instruction after the branch has already been fetched. The unit holds the fetch program counter and the valid bit of the fetch/decode register. Each cycle it picks the next fetch address, and it decides whether the instruction just fetched survives or becomes a bubble.

A two-bit run-time input picks one of three ways to handle the wrong-path fetch. The first stalls fetch for one cycle on every branch. The second keeps fetching sequentially and cancels the fetched instruction only when the branch is taken. The third uses a single architectural delay slot: the instruction after the branch always executes. A branch found inside a delay slot is illegal. The unit reports it and does not follow it. Register-write and memory-write enables from decode are gated by the valid bit, so a bubble never writes state. Two counters record the cycles lost under the stall policy and under the squash policy.

Top module: `brhaz_ctrl`

## Requirements
- R1: While reset is low at a clock edge, the unit sets the fetch address to RESET_PC (default 0x100). It also clears the decode valid bit and both lost-cycle counters, and it drives stall, kill and slot error low.
- R2: When no valid branch is in decode, the next fetch address is the current fetch address plus 4. Stall and kill stay low, and the fetched instruction is valid in decode one cycle later.
- R3: Under policy code 0 (code 3 behaves the same way), a valid branch drives stall and kill high in that cycle, whatever its outcome. The next fetch address is the target if the branch is taken, and otherwise the current fetch address, which is held. Decode holds a bubble in the following cycle.
- R4: Under policy code 1, a not-taken branch leaves stall and kill low and moves fetch to the current address plus 4. A taken branch raises kill (stall stays low) and redirects fetch to the target.
- R5: Under policy code 2, a branch never raises stall or kill. The next fetch address is the target if the branch is taken, and otherwise the address after the slot (current fetch address plus 4). The slot instruction is valid in decode in the next cycle.
- R6: A valid branch in decode in the cycle right after a code-2 branch raises the slot error output for that cycle. It causes no redirect, stall or kill, and fetch moves on by 4.
- R7: A branch flag that arrives while the decode valid bit is low is ignored: no redirect, no stall, no kill, and no counter change.
- R8: The register-write and memory-write enables pass to the outputs only while the decode valid bit is high. Otherwise both outputs are low.
- R9: The stall counter increments by one for each branch handled under code 0 or 3. The squash counter increments by one for each taken branch under code 1. No other event changes either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_i | input | 2 | Branch policy: 0 stall, 1 not-taken with squash, 2 delay slot, 3 as stall |
| id_branch_i | input | 1 | Instruction in decode is a branch |
| id_taken_i | input | 1 | Resolved outcome of that branch |
| id_target_i | input | AW | Branch target address |
| id_rf_we_i | input | 1 | Register-write enable decoded from the instruction |
| id_mem_we_i | input | 1 | Memory-write enable decoded from the instruction |
| fetch_pc_o | output | AW | Address being fetched this cycle |
| next_pc_o | output | AW | Address to fetch next cycle |
| fetch_stall_o | output | 1 | Fetch held for a policy stall |
| fd_kill_o | output | 1 | Instruction fetched this cycle becomes a bubble |
| dec_valid_o | output | 1 | Valid bit of the fetch/decode register |
| rf_we_o | output | 1 | Gated register-write enable |
| mem_we_o | output | 1 | Gated memory-write enable |
| slot_err_o | output | 1 | Branch found in a delay slot |
| stall_lost_o | output | CW | Cycles lost to policy stalls |
| squash_lost_o | output | CW | Cycles lost to squashes |

## Verification
The bench runs taken and not-taken branches under every policy code, including the reserved code. It looks at the address redirect and at the bubble that appears one cycle later. A design that held fetch only on taken branches in stall mode, or squashed a not-taken branch, would show a wrong next address, a wrong kill or a wrong counter value. Delay-slot branches are checked to keep the slot instruction valid. A branch placed in the slot must raise the error and must not redirect; a design that followed it would jump to the second target. A branch flag sent during a bubble, and write enables sent during a bubble, must have no effect. A design that failed to qualify either by the valid bit would redirect, count a lost cycle, or let a write escape.

// File: rtl/bhu_pkg.sv
// Package: shared types for the branch control hazard unit.
// Assumes policy codes are fixed by the requirements; code 3 is a reserved alias of stall.
package bhu_pkg;

    typedef enum logic [1:0] {
        POL_STALL  = 2'd0,
        POL_SQUASH = 2'd1,
        POL_DSLOT  = 2'd2,
        POL_RSVD   = 2'd3
    } policy_e;

    // Per-cycle control decision produced by the policy logic.
    typedef struct packed {
        logic stall;        // hold fetch this cycle
        logic kill;         // fetched instruction becomes a bubble
        logic take;         // redirect to target
        logic err;          // branch found in a delay slot
        logic opens_slot;   // next decode instruction is a delay slot
        logic lost_stall;   // one cycle lost to a policy stall
        logic lost_squash;  // one cycle lost to a squash
    } hz_ctl_t;

    localparam int unsigned NUM_LOST_CTR = 2;

endpackage

// File: rtl/bhu_decide.sv
// Module: bhu_decide
// Combinational policy decision for one decode-stage branch.
// Assumes br_valid is already qualified by the decode valid bit and that
// the outcome is final in the same cycle.
module bhu_decide
    import bhu_pkg::*;
(
    input  policy_e  policy,
    input  logic     br_valid,
    input  logic     taken,
    input  logic     in_slot,
    output hz_ctl_t  ctl
);

    // Pick stall/kill/redirect from the selected policy and the outcome.
    always_comb begin
        ctl = '0;
        if (br_valid) begin
            if (in_slot) begin
                ctl.err = 1'b1;
            end else begin
                case (policy)
                    POL_SQUASH: begin
                        ctl.take        = taken;
                        ctl.kill        = taken;
                        ctl.lost_squash = taken;
                    end
                    POL_DSLOT: begin
                        ctl.take       = taken;
                        ctl.opens_slot = 1'b1;
                    end
                    default: begin
                        ctl.stall      = 1'b1;
                        ctl.kill       = 1'b1;
                        ctl.take       = taken;
                        ctl.lost_stall = 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/bhu_fetch.sv
// Module: bhu_fetch
// Holds the fetch PC, the fetch/decode valid bit and the delay-slot flag.
// Assumes fixed-size instructions of INSTR_BYTES and a fetch every cycle.
module bhu_fetch
    import bhu_pkg::*;
#(
    parameter int unsigned      AW          = 32,
    parameter int unsigned      INSTR_BYTES = 4,
    parameter logic [AW-1:0]    RESET_PC    = 32'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  hz_ctl_t         ctl,
    input  logic [AW-1:0]   target,
    output logic [AW-1:0]   pc_q,
    output logic [AW-1:0]   next_pc,
    output logic            fd_valid,
    output logic            in_slot
);

    localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

    // Select the next fetch address: target, held PC, or sequential.
    always_comb begin
        if (ctl.take)
            next_pc = target;
        else if (ctl.stall)
            next_pc = pc_q;
        else
            next_pc = pc_q + STEP;
    end

    // Advance the PC and load the decode valid bit and slot flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_PC;
            fd_valid <= 1'b0;
            in_slot  <= 1'b0;
        end else begin
            pc_q     <= next_pc;
            fd_valid <= ~ctl.kill;
            in_slot  <= ctl.opens_slot;
        end
    end

    p_kill_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.kill |=> !fd_valid);

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.stall && !ctl.take) |=> (pc_q == $past(pc_q)));

    p_slot_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.opens_slot |=> (fd_valid && in_slot));

endmodule

// File: rtl/bhu_lost_ctr.sv
// Module: bhu_lost_ctr
// Wrapping counter of lost cycles for one policy.
// Assumes at most one lost cycle per clock.
module bhu_lost_ctr #(
    parameter int unsigned CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    output logic [CW-1:0]   cnt
);

    // Count one per lost-cycle event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + CW'(1);
    end

    p_ctr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));

    p_ctr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt != $past(cnt)));

endmodule

// File: rtl/brhaz_ctrl.sv
// Module: brhaz_ctrl (top)
// Branch control hazard unit: fetch redirect, stall and squash under a
// run-time policy, with lost-cycle counters per policy.
// Assumes the branch resolves in decode, one stage after fetch.
module brhaz_ctrl
    import bhu_pkg::*;
#(
    parameter int unsigned      AW          = 32,
    parameter int unsigned      CW          = 16,
    parameter int unsigned      INSTR_BYTES = 4,
    parameter logic [AW-1:0]    RESET_PC    = 32'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      policy_i,
    input  logic            id_branch_i,
    input  logic            id_taken_i,
    input  logic [AW-1:0]   id_target_i,
    input  logic            id_rf_we_i,
    input  logic            id_mem_we_i,
    output logic [AW-1:0]   fetch_pc_o,
    output logic [AW-1:0]   next_pc_o,
    output logic            fetch_stall_o,
    output logic            fd_kill_o,
    output logic            dec_valid_o,
    output logic            rf_we_o,
    output logic            mem_we_o,
    output logic            slot_err_o,
    output logic [CW-1:0]   stall_lost_o,
    output logic [CW-1:0]   squash_lost_o
);

    policy_e                 policy;
    hz_ctl_t                 ctl;
    logic                    fd_valid;
    logic                    in_slot;
    logic                    br_valid;
    logic [NUM_LOST_CTR-1:0] lost_inc;
    logic [CW-1:0]           lost_cnt [NUM_LOST_CTR];

    // Qualify the branch flag and decode the policy code.
    always_comb begin
        policy   = policy_e'(policy_i);
        br_valid = id_branch_i & fd_valid;
        lost_inc = {ctl.lost_squash, ctl.lost_stall};
    end

    bhu_decide u_decide (
        .policy   (policy),
        .br_valid (br_valid),
        .taken    (id_taken_i),
        .in_slot  (in_slot),
        .ctl      (ctl)
    );

    bhu_fetch #(
        .AW          (AW),
        .INSTR_BYTES (INSTR_BYTES),
        .RESET_PC    (RESET_PC)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .target   (id_target_i),
        .pc_q     (fetch_pc_o),
        .next_pc  (next_pc_o),
        .fd_valid (fd_valid),
        .in_slot  (in_slot)
    );

    for (genvar g = 0; g < NUM_LOST_CTR; g++) begin : g_lost
        bhu_lost_ctr #(.CW(CW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (lost_inc[g]),
            .cnt   (lost_cnt[g])
        );
    end

    // Drive status outputs and gate the write enables with the valid bit.
    always_comb begin
        fetch_stall_o = ctl.stall;
        fd_kill_o     = ctl.kill;
        slot_err_o    = ctl.err;
        dec_valid_o   = fd_valid;
        rf_we_o       = id_rf_we_i & fd_valid;
        mem_we_o      = id_mem_we_i & fd_valid;
        stall_lost_o  = lost_cnt[0];
        squash_lost_o = lost_cnt[1];
    end

    p_stall_kills_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall_o |-> fd_kill_o);

    p_nt_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd1 && !id_taken_i) |-> (!fd_kill_o && !fetch_stall_o));

    p_dslot_nokill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd2) |-> (!fd_kill_o && !fetch_stall_o));

    p_slot_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err_o |-> (!fd_kill_o && !fetch_stall_o && next_pc_o == fetch_pc_o + AW'(INSTR_BYTES)));

    p_bubble_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_o |-> (!fd_kill_o && !slot_err_o));

    p_we_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o || mem_we_o) |-> dec_valid_o);

endmodule

// File: tb/sim_brhaz_ctrl.sv
`timescale 1ns/1ps
module sim_brhaz_ctrl;

    localparam int AW = 32;
    localparam int CW = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      policy_i;
    logic            id_branch_i, id_taken_i, id_rf_we_i, id_mem_we_i;
    logic [AW-1:0]   id_target_i;
    logic [AW-1:0]   fetch_pc_o, next_pc_o;
    logic            fetch_stall_o, fd_kill_o, dec_valid_o, rf_we_o, mem_we_o, slot_err_o;
    logic [CW-1:0]   stall_lost_o, squash_lost_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_st = 0;
    int exp_sq = 0;

    always #2 clk = ~clk;

    brhaz_ctrl u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        id_branch_i = 0; id_taken_i = 0; id_target_i = '0;
        id_rf_we_i = 0; id_mem_we_i = 0;
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 pc", fetch_pc_o, 32'h100);
        chk("R1 valid", dec_valid_o, 0);
        chk("R1 stall cnt", stall_lost_o, 0);
        chk("R1 squash cnt", squash_lost_o, 0);
        chk("R1 kill", fd_kill_o, 0);
        chk("R1 err", slot_err_o, 0);
    endtask

    // R2: one cycle with no branch, sequential fetch.
    task automatic t_idle();
        logic [AW-1:0] pc0;
        @(negedge clk); clear_in(); #1;
        pc0 = fetch_pc_o;
        chk("R2 next", next_pc_o, pc0 + 4);
        chk("R2 stall", fetch_stall_o, 0);
        chk("R2 kill", fd_kill_o, 0);
        @(negedge clk); #1;
        chk("R2 pc", fetch_pc_o, pc0 + 4);
        chk("R2 valid", dec_valid_o, 1);
    endtask

    // R3/R4/R5/R9: one valid branch under a policy.
    task automatic t_branch(logic [1:0] pol, logic tk, logic [AW-1:0] tgt);
        logic [AW-1:0] pc0, exp_next;
        logic st, kl;
        @(negedge clk);
        policy_i = pol; id_branch_i = 1; id_taken_i = tk; id_target_i = tgt;
        #1;
        pc0 = fetch_pc_o;
        st  = (pol == 2'd0 || pol == 2'd3);
        kl  = st || (pol == 2'd1 && tk);
        exp_next = tk ? tgt : (st ? pc0 : pc0 + 4);
        if (st) exp_st++;
        if (pol == 2'd1 && tk) exp_sq++;
        chk("R3/R4/R5 next", next_pc_o, exp_next);
        chk("R3/R4/R5 stall", fetch_stall_o, st);
        chk("R3/R4/R5 kill", fd_kill_o, kl);
        chk("R6 err low", slot_err_o, 0);
        @(negedge clk); clear_in(); #1;
        chk("R3/R4/R5 pc", fetch_pc_o, exp_next);
        chk("R3/R5 valid", dec_valid_o, !kl);
        chk("R9 stall cnt", stall_lost_o, exp_st);
        chk("R9 squash cnt", squash_lost_o, exp_sq);
    endtask

    // R6: branch sitting in a delay slot.
    task automatic t_slot_illegal();
        t_branch(2'd2, 1'b1, 32'h400);
        id_branch_i = 1; id_taken_i = 1; id_target_i = 32'h800; #1;
        chk("R6 err", slot_err_o, 1);
        chk("R6 kill", fd_kill_o, 0);
        chk("R6 next", next_pc_o, 32'h404);
        @(negedge clk); clear_in(); #1;
        chk("R6 pc", fetch_pc_o, 32'h404);
        chk("R6 err clears", slot_err_o, 0);
    endtask

    // R7/R8: branch flag and write enables during a bubble.
    task automatic t_bubble();
        logic [AW-1:0] pc0;
        t_branch(2'd0, 1'b0, 32'h0);
        policy_i = 2'd1; id_branch_i = 1; id_taken_i = 1; id_target_i = 32'h900;
        id_rf_we_i = 1; id_mem_we_i = 1; #1;
        pc0 = fetch_pc_o;
        chk("R7 kill", fd_kill_o, 0);
        chk("R7 next", next_pc_o, pc0 + 4);
        chk("R8 rf_we bubble", rf_we_o, 0);
        chk("R8 mem_we bubble", mem_we_o, 0);
        @(negedge clk); id_branch_i = 0; #1;
        chk("R7 pc", fetch_pc_o, pc0 + 4);
        chk("R7 squash cnt", squash_lost_o, exp_sq);
        chk("R8 rf_we valid", rf_we_o, 1);
        chk("R8 mem_we valid", mem_we_o, 1);
        clear_in();
    endtask

    initial begin
        rst_n = 0; policy_i = 0; clear_in();
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1;
        repeat (3) t_idle();
        t_branch(2'd0, 1'b0, 32'h200); t_idle();
        t_branch(2'd0, 1'b1, 32'h300); t_idle();
        t_branch(2'd3, 1'b1, 32'h340); t_idle();
        t_branch(2'd1, 1'b0, 32'h500); t_idle();
        t_branch(2'd1, 1'b1, 32'h600); t_idle();
        t_branch(2'd2, 1'b1, 32'h700); t_idle();
        t_branch(2'd2, 1'b0, 32'h780); t_idle();
        t_slot_illegal(); t_idle();
        t_bubble(); t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule